// File: doc/BRIEF.md
# Bus Cycle Termination Decoder

This block watches the three active-low termination strobes of a processor bus while a bus cycle is in progress. On every rising clock edge it sorts the current beat into one of five outcomes: keep waiting, normal completion, retry, bus error, or an illegal strobe combination. The illegal case is handled as a bus error. Two acknowledge schemes can be selected. The legacy scheme signals a retry by asserting the error strobe together with the acknowledge strobe. The native scheme uses a dedicated retry strobe.

A four-long-word line transfer may run as one burst. It may also run as a chain of separate single long-word cycles when bursting is inhibited. In both cases the block tracks which long word of the line is being terminated. A retry is only valid on the first long word. On a later long word the legacy scheme turns it into a bus error, and the native scheme discards it. An optional timeout counter forces an error termination when no acknowledge arrives within a programmed number of clocks. Results leave the block as one-clock pulses, together with the index of the beat that produced them.

Top module: `bus_term_decoder`

## Requirements
- R1: With all three strobes high (negated) during an active cycle, no result pulse is produced, in either scheme.
- R2: Legacy scheme (native_i=0): error strobe low with acknowledge high gives a berr_o pulse one clock after the sampling edge.
- R3: Legacy scheme: acknowledge and error strobes both low on the first long word give a retry_o pulse with beat_o=0.
- R4: Legacy scheme: acknowledge low with error high gives a done_o pulse. The retry strobe has no effect in this scheme.
- R5: Native scheme (native_i=1): error strobe low gives berr_o, whatever the levels of the acknowledge and retry strobes.
- R6: Native scheme: retry strobe low with error and acknowledge high on the first long word gives retry_o. Acknowledge low alone gives done_o.
- R7: Native scheme: acknowledge and retry strobes both low with error high gives illegal_o and berr_o in the same clock.
- R8: In a line transfer (line_i=1), a legacy retry on beat index 1, 2 or 3 is reported as berr_o, with beat_o holding that index.
- R9: In a native line transfer, a retry on beat index 1 to 3 produces no pulse and leaves beat_o unchanged. The cycle stays open and a later acknowledge completes that beat.
- R10: A cycle started with line_i=1 and first_i=0 continues the beat index of the current line (burst inhibited). A cycle started with line_i=0, or with first_i=1, begins at index 0.
- R11: With wd_limit_i=L>0, after L consecutive waiting samples the next waiting sample ends the cycle with berr_o. The count restarts at each cycle start and at each accepted beat.
- R12: With wd_limit_i=0 the timeout never fires, however long the wait.
- R13: At most one of done_o, retry_o and berr_o is high in any clock. beat_o updates only on a terminating beat, to the index of that beat. A burst (burst_i=1) accepts indices 0 to 3 and then closes.
- R14: Strobes sampled while no cycle is active produce no result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| native_i | input | 1 | 1 selects the native scheme, 0 the legacy scheme |
| start_i | input | 1 | One-clock pulse that opens a bus cycle |
| line_i | input | 1 | Taken with start_i: the cycle belongs to a line transfer |
| first_i | input | 1 | Taken with start_i: the cycle begins a new line |
| burst_i | input | 1 | Taken with start_i: four beats in one cycle |
| ta_ni | input | 1 | Acknowledge strobe, active low |
| tea_ni | input | 1 | Error strobe, active low |
| tra_ni | input | 1 | Retry strobe, active low (native scheme only) |
| wd_limit_i | input | WD_W | Timeout in waiting clocks, 0 disables it |
| done_o | output | 1 | Normal completion pulse |
| retry_o | output | 1 | Retry pulse |
| berr_o | output | 1 | Bus error pulse |
| illegal_o | output | 1 | Illegal strobe combination pulse (paired with berr_o) |
| beat_o | output | BEAT_W | Index of the last terminated beat |

## Verification
The bench builds the block with the timeout present, WD_W=4 and BEATS=4. A short limit of 3 puts the exact firing clock of the timeout within reach, along with its reload after each accepted burst beat. A limit of 0 lets a twenty-clock wait run with the timeout disabled. With four beats, a late retry can be placed on an inner beat of a burst and of a burst-inhibited chain in both schemes. The final beat that closes a burst can also be observed, followed by an idle sample after it.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
  typedef enum logic [2:0] {
    TERM_WAIT,
    TERM_NORMAL,
    TERM_RETRY,
    TERM_ERROR,
    TERM_ILLEGAL
  } term_e;
endpackage

// File: rtl/bus_term_classify.sv
module bus_term_classify
  import bus_term_pkg::*;
(
  input  logic  native_i,
  input  logic  ta_ni,
  input  logic  tea_ni,
  input  logic  tra_ni,
  output term_e term_o
);
  always_comb begin
    term_o = TERM_WAIT;
    if (!native_i) begin
      // legacy scheme: retry strobe unused
      case ({ta_ni, tea_ni})
        2'b11:   term_o = TERM_WAIT;
        2'b01:   term_o = TERM_NORMAL;
        2'b10:   term_o = TERM_ERROR;
        default: term_o = TERM_RETRY;
      endcase
    end else if (!tea_ni) begin
      term_o = TERM_ERROR;
    end else begin
      case ({ta_ni, tra_ni})
        2'b11:   term_o = TERM_WAIT;
        2'b01:   term_o = TERM_NORMAL;
        2'b10:   term_o = TERM_RETRY;
        default: term_o = TERM_ILLEGAL;
      endcase
    end
  end
endmodule

// File: rtl/bus_term_watchdog.sv
module bus_term_watchdog #(
  parameter int WD_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WD_W-1:0] limit_i,
  input  logic            clear_i,
  input  logic            tick_i,
  output logic            expired_o
);
  logic [WD_W-1:0] cnt_q;

  assign expired_o = (limit_i != '0) && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (tick_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bus_term_beat.sv
module bus_term_beat #(
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              line_i,
  input  logic              first_i,
  input  logic              burst_i,
  input  logic              advance_i,
  input  logic              end_i,
  output logic              active_o,
  output logic              burst_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      burst_o  <= 1'b0;
      line_q   <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      burst_o  <= burst_i & line_i;
      line_q   <= line_i;
    end else if (end_i) begin
      active_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          beat_o <= '0;
    else if (start_i && (first_i || !line_i)) beat_o <= '0;
    else if (advance_i && line_q)         beat_o <= (beat_o == LAST) ? '0 : beat_o + 1'b1;
  end
endmodule

// File: rtl/bus_term_decoder.sv
module bus_term_decoder
  import bus_term_pkg::*;
#(
  parameter int  WD_W   = 8,
  parameter int  BEATS  = 4,
  parameter bit  WD_EN  = 1'b1,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              native_i,
  input  logic              start_i,
  input  logic              line_i,
  input  logic              first_i,
  input  logic              burst_i,
  input  logic              ta_ni,
  input  logic              tea_ni,
  input  logic              tra_ni,
  input  logic [WD_W-1:0]   wd_limit_i,
  output logic              done_o,
  output logic              retry_o,
  output logic              berr_o,
  output logic              illegal_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  term_e             raw, res;
  logic              active, burst_q, wd_exp;
  logic              advance, cyc_end, tick, wd_clear, late;
  logic [BEAT_W-1:0] cur_beat;

  bus_term_classify u_classify (
    .native_i (native_i),
    .ta_ni    (ta_ni),
    .tea_ni   (tea_ni),
    .tra_ni   (tra_ni),
    .term_o   (raw)
  );

  bus_term_beat #(.BEATS(BEATS)) u_beat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .line_i    (line_i),
    .first_i   (first_i),
    .burst_i   (burst_i),
    .advance_i (advance),
    .end_i     (cyc_end),
    .active_o  (active),
    .burst_o   (burst_q),
    .beat_o    (cur_beat)
  );

  generate
    if (WD_EN) begin : g_wd
      bus_term_watchdog #(.WD_W(WD_W)) u_wd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .limit_i   (wd_limit_i),
        .clear_i   (wd_clear),
        .tick_i    (tick),
        .expired_o (wd_exp)
      );
    end else begin : g_no_wd
      assign wd_exp = 1'b0;
    end
  endgenerate

  assign late = (cur_beat != '0);

  always_comb begin
    res = raw;
    // retry only valid on the first long word of a line
    if (raw == TERM_RETRY && late) res = native_i ? TERM_WAIT : TERM_ERROR;
    if (res == TERM_WAIT && wd_exp) res = TERM_ERROR;
    if (!active) res = TERM_WAIT;
  end

  assign advance  = (res == TERM_NORMAL);
  assign cyc_end  = (res == TERM_ERROR) || (res == TERM_ILLEGAL) || (res == TERM_RETRY) ||
                    (advance && (!burst_q || cur_beat == LAST));
  assign tick     = active && (res == TERM_WAIT);
  assign wd_clear = start_i || advance || cyc_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      retry_o   <= 1'b0;
      berr_o    <= 1'b0;
      illegal_o <= 1'b0;
      beat_o    <= '0;
    end else begin
      done_o    <= (res == TERM_NORMAL);
      retry_o   <= (res == TERM_RETRY);
      berr_o    <= (res == TERM_ERROR) || (res == TERM_ILLEGAL);
      illegal_o <= (res == TERM_ILLEGAL);
      if (res != TERM_WAIT) beat_o <= cur_beat;
    end
  end

  assert_one_result_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, retry_o, berr_o}));

  assert_illegal_is_error_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> berr_o);

  assert_idle_quiet_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !(done_o || retry_o || berr_o));

  assert_retry_first_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (beat_o == '0));

  assert_timeout_error_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && wd_exp && raw == TERM_WAIT) |=> berr_o);
endmodule

// File: tb/bus_term_decoder_bench.sv
module bus_term_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_W = 4;
  localparam int BEATS = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       native_i = 1'b0;
  logic       start_i = 1'b0, line_i = 1'b0, first_i = 1'b0, burst_i = 1'b0;
  logic       ta_ni = 1'b1, tea_ni = 1'b1, tra_ni = 1'b1;
  logic [WD_W-1:0] wd_limit_i = '0;
  logic       done_o, retry_o, berr_o, illegal_o;
  logic [1:0] beat_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_term_decoder #(.WD_W(WD_W), .BEATS(BEATS), .WD_EN(1'b1)) u_bus_term_decoder (
    .clk_i, .rst_ni, .native_i, .start_i, .line_i, .first_i, .burst_i,
    .ta_ni, .tea_ni, .tra_ni, .wd_limit_i,
    .done_o, .retry_o, .berr_o, .illegal_o, .beat_o
  );

  // flags = {done, retry, berr, illegal}
  task automatic expect_out(input string req, input logic [3:0] ev, input logic [1:0] eb);
    checks++;
    if ({done_o, retry_o, berr_o, illegal_o} !== ev || beat_o !== eb) begin
      errors++;
      $display("FAIL %s: flags=%b beat=%0d expected flags=%b beat=%0d",
               req, {done_o, retry_o, berr_o, illegal_o}, beat_o, ev, eb);
    end
  endtask

  task automatic expect_flags(input string req, input logic [3:0] ev);
    checks++;
    if ({done_o, retry_o, berr_o, illegal_o} !== ev) begin
      errors++;
      $display("FAIL %s: flags=%b expected flags=%b", req,
               {done_o, retry_o, berr_o, illegal_o}, ev);
    end
  endtask

  task automatic open_cycle(input logic ln, input logic fst, input logic bst);
    @(negedge clk_i);
    start_i = 1'b1; line_i = ln; first_i = fst; burst_i = bst;
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic beat(input logic ta, input logic tea, input logic tra);
    @(negedge clk_i);
    ta_ni = ta; tea_ni = tea; tra_ni = tra;
    @(posedge clk_i); #1;
    ta_ni = 1'b1; tea_ni = 1'b1; tra_ni = 1'b1;
  endtask

  task automatic t_reset;
    expect_out("R13 reset", 4'b0000, 2'd0);
  endtask

  task automatic t_legacy_basic;
    native_i = 1'b0;
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(1, 1, 1); expect_flags("R1 legacy wait", 4'b0000);
    beat(1, 1, 0); expect_flags("R4 legacy retry strobe ignored", 4'b0000);
    beat(0, 1, 1); expect_out("R4 legacy normal", 4'b1000, 2'd0);
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(1, 0, 1); expect_out("R2 legacy error", 4'b0010, 2'd0);
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(0, 0, 1); expect_out("R3 legacy retry", 4'b0100, 2'd0);
  endtask

  task automatic t_native_basic;
    native_i = 1'b1;
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(1, 1, 1); expect_flags("R1 native wait", 4'b0000);
    beat(1, 1, 0); expect_out("R6 native retry", 4'b0100, 2'd0);
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(0, 0, 0); expect_flags("R5 native error all low", 4'b0010);
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(1, 0, 1); expect_flags("R5 native error alone", 4'b0010);
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(0, 1, 0); expect_flags("R7 native illegal", 4'b0011);
    open_cycle(1'b0, 1'b1, 1'b0);
    beat(0, 1, 1); expect_flags("R6 native normal", 4'b1000);
  endtask

  task automatic t_legacy_burst_retry;
    native_i = 1'b0;
    open_cycle(1'b1, 1'b1, 1'b1);
    beat(0, 1, 1); expect_out("R13 burst beat 0", 4'b1000, 2'd0);
    beat(0, 1, 1); expect_out("R13 burst beat 1", 4'b1000, 2'd1);
    beat(0, 0, 1); expect_out("R8 late legacy retry", 4'b0010, 2'd2);
    beat(0, 1, 1); expect_flags("R14 after error closes", 4'b0000);
  endtask

  task automatic t_native_burst_retry;
    native_i = 1'b1;
    open_cycle(1'b1, 1'b1, 1'b1);
    beat(0, 1, 1); expect_out("R13 native burst beat 0", 4'b1000, 2'd0);
    beat(1, 1, 0); expect_out("R9 late native retry ignored", 4'b0000, 2'd0);
    beat(0, 1, 1); expect_out("R9 beat 1 after ignored retry", 4'b1000, 2'd1);
    beat(0, 1, 1); expect_out("R13 native burst beat 2", 4'b1000, 2'd2);
    beat(0, 1, 1); expect_out("R13 native burst beat 3", 4'b1000, 2'd3);
    beat(0, 1, 1); expect_out("R14 burst closed after beat 3", 4'b0000, 2'd3);
  endtask

  task automatic t_inhibit;
    native_i = 1'b0;
    open_cycle(1'b1, 1'b1, 1'b0);
    beat(0, 1, 1); expect_out("R10 inhibited piece 0", 4'b1000, 2'd0);
    open_cycle(1'b1, 1'b0, 1'b0);
    beat(0, 1, 1); expect_out("R10 inhibited piece 1", 4'b1000, 2'd1);
    open_cycle(1'b1, 1'b0, 1'b0);
    beat(0, 0, 1); expect_out("R10 inhibited late retry legacy", 4'b0010, 2'd2);
    open_cycle(1'b0, 1'b0, 1'b0);
    beat(0, 0, 1); expect_out("R10 non-line restarts index", 4'b0100, 2'd0);
    native_i = 1'b1;
    open_cycle(1'b1, 1'b1, 1'b0);
    beat(0, 1, 1); expect_out("R10 native piece 0", 4'b1000, 2'd0);
    open_cycle(1'b1, 1'b0, 1'b0);
    beat(1, 1, 0); expect_out("R10 native inhibited retry ignored", 4'b0000, 2'd0);
    beat(0, 1, 1); expect_out("R10 native piece 1", 4'b1000, 2'd1);
  endtask

  task automatic t_idle;
    native_i = 1'b0;
    beat(0, 1, 1); expect_flags("R14 idle ack", 4'b0000);
    beat(1, 0, 1); expect_flags("R14 idle error", 4'b0000);
    beat(0, 0, 1); expect_flags("R14 idle retry", 4'b0000);
  endtask

  task automatic t_watchdog;
    native_i = 1'b0;
    wd_limit_i = 4'd3;
    open_cycle(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      beat(1, 1, 1); expect_flags("R11 wait before limit", 4'b0000);
    end
    beat(1, 1, 1); expect_out("R11 timeout fires", 4'b0010, 2'd0);
    open_cycle(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 2; i++) beat(1, 1, 1);
    beat(0, 1, 1); expect_flags("R11 reload at start", 4'b1000);
    open_cycle(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) beat(1, 1, 1);
    beat(0, 1, 1); expect_out("R11 burst beat 0 in time", 4'b1000, 2'd0);
    for (int i = 0; i < 3; i++) beat(1, 1, 1);
    expect_flags("R11 reload after accepted beat", 4'b0000);
    beat(0, 1, 1); expect_out("R11 burst beat 1 in time", 4'b1000, 2'd1);
    for (int i = 0; i < 3; i++) beat(1, 1, 1);
    beat(1, 1, 1); expect_out("R11 timeout on beat 2", 4'b0010, 2'd2);
    wd_limit_i = '0;
    open_cycle(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      beat(1, 1, 1); expect_flags("R12 disabled timeout", 4'b0000);
    end
    beat(0, 1, 1); expect_out("R12 late ack accepted", 4'b1000, 2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 t_reset;
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset;
    t_legacy_basic;
    t_native_basic;
    t_legacy_burst_retry;
    t_native_burst_retry;
    t_inhibit;
    t_idle;
    t_watchdog;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule